// File: doc/BRIEF.md
# Debug Port Serial Shift Interface

This block is the serial link between on-chip debug support logic and an external debug tool. It is full duplex: each bit shifted in on the serial data input is matched by one bit shifted out on the serial data output. Every transfer is a framed unit. A start bit of 1 is followed by a mode bit, a control bit and a 32-bit payload, all sent most significant bit first. While the port is idle it drives 0 on the output, which is its ready indication. Idle zeros on the input are ignored. Because of this framing, the tool may run the serial clock freely and does not need to gate it around transfers.

Two strap levels are read on the first system clock edge after reset is released. The data-input level selects the clocking mode. The clock-input level selects whether the freeze output rises at once or waits for a later debug event. In external-clock mode, both serial pins pass through a synchronizer into the system clock domain, and each rising edge of the serial clock moves one bit. In system-clock mode, one bit moves on every system clock edge.

A received frame is presented on a parallel output with a one-cycle valid strobe. The outgoing payload comes from a one-entry holding register that is filled over a valid/ready input. The receive side has no back-pressure: the strobe arrives once per frame, and the consumer must take it in that cycle. On the response side, ready is low while the holding register is full, and it returns high once a start bit consumes the word.

Top module: `dbg_serial_port`

## Requirements
- R1: On the first rising system clock edge after `rst_n` is released, `ser_din_i` is latched as the clock mode, where 0 selects external-clock mode and 1 selects system-clock mode. In external-clock mode, a held input level with no serial clock edge moves no bit.
- R2: If `ser_clk_i` is 1 at that same edge, `freeze_o` is 1 from that edge on. If it is 0, `freeze_o` stays 0 until a cycle with `dbg_event_i` high. Once `freeze_o` is 1, it stays 1 until reset.
- R3: While idle, `ser_dout_o` is 0. Input bits of value 0 seen while idle start nothing: no strobe is produced and the output stays 0.
- R4: An input frame is a start bit of 1, then a mode bit, a control bit and 32 payload bits, MSB first. After the last payload bit, `rx_valid_o` is high for exactly one cycle, and `rx_mode_o`, `rx_ctrl_o` and `rx_data_o` hold the frame's fields until the next frame completes.
- R5: The output frame is 34 bits. Bit 33 is 1 when a response word was loaded, bit 32 is the value of `freeze_o` at the start bit, and bits 31..0 are the response word, or zero when no word was loaded. Bit 33 appears on `ser_dout_o` after the start-bit shift, and each later shift presents the next lower bit. The shift that takes the last payload bit returns the output to 0.
- R6: In external-clock mode, one bit is taken per rising edge of `ser_clk_i`. The pins pass through a 2-stage synchronizer, so each level of `ser_clk_i` must last at least 3 system clocks. The tool reads `ser_dout_o` just before each rising serial edge.
- R7: In system-clock mode, one bit is taken on every rising system clock edge, and `ser_dout_o` changes on that same edge.
- R8: `resp_ready_o` is 1 exactly when the holding register is empty. A word accepted with `resp_valid_i` and `resp_ready_o` both high makes `resp_ready_o` 0 on the next cycle. The next start bit consumes the word and sets `resp_ready_o` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the tool; strap for freeze at reset |
| ser_din_i | input | 1 | Serial data from the tool; strap for clock mode at reset |
| ser_dout_o | output | 1 | Serial data to the tool; 0 when idle |
| freeze_o | output | 1 | Debug freeze status, sticky until reset |
| dbg_event_i | input | 1 | Debug event that raises freeze |
| resp_valid_i | input | 1 | Response word offered |
| resp_ready_o | output | 1 | Holding register empty |
| resp_data_i | input | 32 | Response word |
| rx_valid_o | output | 1 | One-cycle strobe for a received frame |
| rx_mode_o | output | 1 | Received mode bit |
| rx_ctrl_o | output | 1 | Received control bit |
| rx_data_o | output | 32 | Received payload |

## Verification
The hardest states to reach are the strap-dependent ones, because the mode and the freeze choice can only change through a fresh reset with the pins held at chosen levels. The bench therefore runs two reset phases. The first uses external-clock mode with a deferred freeze. The second uses system-clock mode with an immediate freeze. In each phase it sends frames with and without a preloaded response word. In external-clock mode it also holds the data input high with no serial edge, to show that level alone moves nothing.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic {
    CLK_EXT = 1'b0,
    CLK_SYS = 1'b1
  } clk_mode_e;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;

  // mode bit + control bit ahead of the payload
  localparam int HDR_BITS = 2;
endpackage

// File: rtl/dbgp_strap.sv
module dbgp_strap
  import dbgp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_clk_i,
  input  logic      ser_din_i,
  input  logic      dbg_event_i,
  output logic      strap_done_o,
  output clk_mode_e mode_o,
  output logic      freeze_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_o <= 1'b0;
      mode_o       <= CLK_EXT;
      freeze_o     <= 1'b0;
    end else if (!strap_done_o) begin
      strap_done_o <= 1'b1;
      mode_o       <= clk_mode_e'(ser_din_i);
      freeze_o     <= ser_clk_i;
    end else if (dbg_event_i) begin
      freeze_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dbgp_tick.sv
module dbgp_tick
  import dbgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  clk_mode_e mode_i,
  input  logic      ser_clk_i,
  input  logic      ser_din_i,
  output logic      tick_o,
  output logic      bit_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_q;
  logic [SYNC_STAGES-1:0] din_q;
  logic                   clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= '0;
      din_q    <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_q    <= {clk_q[TOP-1:0], ser_clk_i};
      din_q    <= {din_q[TOP-1:0], ser_din_i};
      clk_last <= clk_q[TOP];
    end
  end

  always_comb begin
    if (mode_i == CLK_SYS) begin
      tick_o = en_i;
      bit_o  = ser_din_i;
    end else begin
      tick_o = en_i & clk_q[TOP] & ~clk_last;
      bit_o  = din_q[TOP];
    end
  end
endmodule

// File: rtl/dbgp_resp_buf.sv
module dbgp_resp_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] word_o
);
  logic accept;
  assign ready_o = ~full_o;
  assign accept  = valid_i & ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      word_o <= '0;
    end else begin
      if (accept) begin
        full_o <= 1'b1;
        word_o <= data_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbgp_shifter.sv
module dbgp_shifter
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bit_i,
  input  logic              resp_full_i,
  input  logic [DATA_W-1:0] resp_word_i,
  input  logic              freeze_i,
  output logic              take_o,
  output logic              dout_o,
  output logic              rx_valid_o,
  output logic              rx_mode_o,
  output logic              rx_ctrl_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int FR_W  = DATA_W + HDR_BITS;
  localparam int CNT_W = $clog2(FR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FR_W - 1);

  sh_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [FR_W-2:0]  rx_sr;
  logic [FR_W-1:0]  tx_sr;
  logic [FR_W-1:0]  load_word;
  logic [FR_W-1:0]  rx_full;

  assign load_word = resp_full_i ? {1'b1, freeze_i, resp_word_i}
                                 : {1'b0, freeze_i, {DATA_W{1'b0}}};
  assign take_o    = tick_i & (state == SH_IDLE) & bit_i;
  assign rx_full   = {rx_sr, bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SH_IDLE;
      cnt        <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      dout_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_mode_o  <= 1'b0;
      rx_ctrl_o  <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (tick_i) begin
        if (state == SH_IDLE) begin
          if (bit_i) begin
            state  <= SH_BUSY;
            cnt    <= '0;
            tx_sr  <= load_word;
            dout_o <= load_word[FR_W-1];
          end else begin
            dout_o <= 1'b0;
          end
        end else begin
          rx_sr <= {rx_sr[FR_W-3:0], bit_i};
          if (cnt == LAST) begin
            state      <= SH_IDLE;
            dout_o     <= 1'b0;
            rx_valid_o <= 1'b1;
            rx_mode_o  <= rx_full[FR_W-1];
            rx_ctrl_o  <= rx_full[FR_W-2];
            rx_data_o  <= rx_full[DATA_W-1:0];
          end else begin
            cnt    <= cnt + 1'b1;
            tx_sr  <= tx_sr << 1;
            dout_o <= tx_sr[FR_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic              freeze_o,
  input  logic              dbg_event_i,
  input  logic              resp_valid_i,
  output logic              resp_ready_o,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              rx_valid_o,
  output logic              rx_mode_o,
  output logic              rx_ctrl_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic              strap_done;
  clk_mode_e         clk_mode;
  logic              tick;
  logic              sbit;
  logic              take;
  logic              resp_full;
  logic [DATA_W-1:0] resp_word;

  dbgp_strap strap_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk_i    (ser_clk_i),
    .ser_din_i    (ser_din_i),
    .dbg_event_i  (dbg_event_i),
    .strap_done_o (strap_done),
    .mode_o       (clk_mode),
    .freeze_o     (freeze_o)
  );

  dbgp_tick #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (strap_done),
    .mode_i    (clk_mode),
    .ser_clk_i (ser_clk_i),
    .ser_din_i (ser_din_i),
    .tick_o    (tick),
    .bit_o     (sbit)
  );

  dbgp_resp_buf #(.DATA_W(DATA_W)) resp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (resp_valid_i),
    .data_i  (resp_data_i),
    .ready_o (resp_ready_o),
    .take_i  (take),
    .full_o  (resp_full),
    .word_o  (resp_word)
  );

  dbgp_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .bit_i       (sbit),
    .resp_full_i (resp_full),
    .resp_word_i (resp_word),
    .freeze_i    (freeze_o),
    .take_o      (take),
    .dout_o      (ser_dout_o),
    .rx_valid_o  (rx_valid_o),
    .rx_mode_o   (rx_mode_o),
    .rx_ctrl_o   (rx_ctrl_o),
    .rx_data_o   (rx_data_o)
  );
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_dout_o,
  input logic              freeze_o,
  input logic              resp_valid_i,
  input logic              resp_ready_o,
  input logic              rx_valid_o,
  input logic              rx_ctrl_o,
  input logic [DATA_W-1:0] rx_data_o
);
  // R2
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |=> freeze_o);

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> ($stable(rx_data_o) && $stable(rx_ctrl_o)));

  // R5
  end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !ser_dout_o);

  // R8
  resp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_i && resp_ready_o) |=> !resp_ready_o);
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ser_dout_o   (ser_dout_o),
  .freeze_o     (freeze_o),
  .resp_valid_i (resp_valid_i),
  .resp_ready_o (resp_ready_o),
  .rx_valid_o   (rx_valid_o),
  .rx_ctrl_o    (rx_ctrl_o),
  .rx_data_o    (rx_data_o)
);

// File: tb/dbg_serial_port_tb_top.sv
module dbg_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout;
  logic        freeze;
  logic        dbg_event = 1'b0;
  logic        resp_valid = 1'b0;
  logic        resp_ready;
  logic [31:0] resp_data = '0;
  logic        rx_valid;
  logic        rx_mode;
  logic        rx_ctrl;
  logic [31:0] rx_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [33:0] exp_q[$];

  always #5 clk = ~clk;

  dbg_serial_port dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk_i    (ser_clk),
    .ser_din_i    (ser_din),
    .ser_dout_o   (ser_dout),
    .freeze_o     (freeze),
    .dbg_event_i  (dbg_event),
    .resp_valid_i (resp_valid),
    .resp_ready_o (resp_ready),
    .resp_data_i  (resp_data),
    .rx_valid_o   (rx_valid),
    .rx_mode_o    (rx_mode),
    .rx_ctrl_o    (rx_ctrl),
    .rx_data_o    (rx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected frames as the strobe appears (R4)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", {rx_mode, rx_ctrl, rx_data}, 0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({rx_mode, rx_ctrl, rx_data} == e, "R4 frame fields",
            {rx_mode, rx_ctrl, rx_data}, e);
      end
    end
  end

  task automatic do_reset(input logic din_strap, input logic clk_strap);
    @(negedge clk);
    rst_n   = 1'b0;
    ser_din = din_strap;
    ser_clk = clk_strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ser_din = 1'b0;
    ser_clk = 1'b0;
  endtask

  task automatic push_resp(input logic [31:0] w);
    @(negedge clk);
    while (!resp_ready) @(negedge clk);
    resp_valid = 1'b1;
    resp_data  = w;
    @(negedge clk);
    resp_valid = 1'b0;
    chk(resp_ready == 1'b0, "R8 ready drops after accept", resp_ready, 0);
  endtask

  task automatic send_ext(input logic m, input logic c, input logic [31:0] p,
                          input logic [33:0] tx);
    logic [34:0] fr;
    fr = {1'b1, m, c, p};
    exp_q.push_back({m, c, p});
    for (int i = 34; i >= 0; i--) begin
      ser_din = fr[i];
      repeat (4) @(negedge clk);
      if (i == 34) chk(ser_dout == 1'b0, "R3 idle output", ser_dout, 0);
      else if (ser_dout !== tx[i]) chk(1'b0, "R5 R6 output bit", ser_dout, tx[i]);
      else chk(1'b1, "R5", 0, 0);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    ser_din = 1'b0;
    repeat (6) @(negedge clk);
    chk(ser_dout == 1'b0, "R5 output back to ready", ser_dout, 0);
  endtask

  task automatic send_sys(input logic m, input logic c, input logic [31:0] p,
                          input logic [33:0] tx);
    logic [34:0] fr;
    fr = {1'b1, m, c, p};
    exp_q.push_back({m, c, p});
    for (int i = 34; i >= 0; i--) begin
      @(negedge clk);
      if (i == 34) chk(ser_dout == 1'b0, "R3 idle output", ser_dout, 0);
      else if (ser_dout !== tx[i]) chk(1'b0, "R7 R5 output bit", ser_dout, tx[i]);
      else chk(1'b1, "R7", 0, 0);
      ser_din = fr[i];
    end
    @(negedge clk);
    ser_din = 1'b0;
    chk(ser_dout == 1'b0, "R5 output back to ready", ser_dout, 0);
  endtask

  initial begin
    // phase A: external clock mode, deferred freeze (R1, R2)
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(freeze == 1'b0, "R2 deferred freeze", freeze, 0);
    chk(ser_dout == 1'b0, "R3 reset output", ser_dout, 0);
    chk(rx_valid == 1'b0, "R4 no strobe at reset", rx_valid, 0);
    chk(resp_ready == 1'b1, "R8 ready when empty", resp_ready, 1);
    // R3: serial edges with zero data while idle
    for (int k = 0; k < 3; k++) begin
      ser_clk = 1'b1; repeat (4) @(negedge clk);
      ser_clk = 1'b0; repeat (4) @(negedge clk);
    end
    chk(ser_dout == 1'b0, "R3 idle zeros ignored", ser_dout, 0);
    // R1 R6: level without serial edge moves nothing
    ser_din = 1'b1;
    repeat (40) @(negedge clk);
    chk(ser_dout == 1'b0, "R1 R6 no edge no shift", ser_dout, 0);
    ser_din = 1'b0;
    repeat (4) @(negedge clk);
    send_ext(1'b1, 1'b0, 32'hDEAD_BEEF, {2'b00, 32'h0});
    push_resp(32'hA5C3_0F96);
    dbg_event = 1'b1;
    @(negedge clk);
    dbg_event = 1'b0;
    @(negedge clk);
    chk(freeze == 1'b1, "R2 event raises freeze", freeze, 1);
    send_ext(1'b0, 1'b1, 32'h0123_4567, {2'b11, 32'hA5C3_0F96});
    chk(resp_ready == 1'b1, "R8 word consumed by start", resp_ready, 1);

    // phase B: system clock mode, immediate freeze (R1, R2, R7)
    do_reset(1'b1, 1'b1);
    chk(freeze == 1'b1, "R2 immediate freeze", freeze, 1);
    repeat (5) @(negedge clk);
    chk(ser_dout == 1'b0, "R3 idle zeros ignored sys", ser_dout, 0);
    push_resp(32'h1357_9BDF);
    send_sys(1'b1, 1'b0, 32'hFFFF_0001, {2'b11, 32'h1357_9BDF});
    push_resp(32'h8000_0001);
    send_sys(1'b0, 1'b1, 32'h0000_0000, {2'b11, 32'h8000_0001});
    send_sys(1'b1, 1'b1, 32'h5A5A_A5A5, {2'b01, 32'h0});
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 every frame strobed", exp_q.size(), 0);
    chk(freeze == 1'b1, "R2 freeze sticky", freeze, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule